// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block derives every digital drive waveform for a two-row color linear CCD from a single system clock. The sensor has one photodiode row that feeds its output directly and a second row whose charge can pass through an on-chip one-line analog delay memory. The generator produces several waveforms. Two complementary shift clocks move charge along the output registers. A narrow reset pulse marks each output pixel. There is a transfer gate for each row. A memory transfer clock controls the delay memory, and it always mirrors the first row's gate.

A mode input selects the readout path. The mode changes only the timing of the memory transfer clock and the second-row gate relative to each other. Every interval is set in system-clock counts on plain inputs: the half pixel period, the line length, the gate width, the gate-to-clocking setup, the memory transfer margin, the reset pulse width and the sampling delay. These settings are captured only when a line begins. For the downstream sampler the block emits a one-cycle line-start strobe and a one-cycle pixel-valid strobe on every pixel.

Top module: `lccd_timing_gen`

## Requirements
- R1: While `rst_n` is low, `shclk1_o` is 1 and every other output is 0. The first line begins on the first rising clock edge after reset is released.
- R2: `shclk1_o` and `shclk2_o` are always complementary. During transfer, each pixel period lasts 2H cycles: `shclk1_o` is low for the first H cycles and high for the last H. H is `half_per_i`, and 0 counts as 1.
- R3: `mem_xfer_o` equals `xgate_a_o` in every cycle.
- R4: With `delay_mode_i` = 0, `xgate_a_o`, `xgate_b_o` and `mem_xfer_o` are high together for the first G cycles of the line. G is `gate_w_i`, and 0 counts as 1.
- R5: With `delay_mode_i` = 1, `xgate_a_o` and `mem_xfer_o` are high for the first G+2M cycles of the line, and `xgate_b_o` is high for G cycles starting M cycles after line start. M is `vt_gap_i`, and 0 counts as 1.
- R6: During the gate window and for U cycles after it, `shclk1_o` stays 1 and `pixrst_o` and `pix_valid_o` stay 0. U is `gate_su_i`, and 0 counts as 1.
- R7: A line runs exactly N transfer periods after its setup interval, where N = max(`line_pix_i`, MIN_PIX). The next line starts in the cycle after the last period ends.
- R8: `pixrst_o` is high for the first W cycles of each pixel period, where W = min(max(`rst_w_i`, 1), H).
- R9: `pix_valid_o` is high for exactly one cycle per pixel period, at offset min(W + `smp_dly_i`, 2H-1) counted from the period's first cycle. It never coincides with `pixrst_o`.
- R10: `line_start_o` is high for one cycle: the first cycle of each line's gate window.
- R11: All settings, including the mode, are taken from the inputs only on the edge that starts a line. A change during a line has no effect until the next line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_mode_i | input | 1 | 1 = readout through the delay memory, 0 = direct |
| half_per_i | input | HW | Half pixel period in cycles (H) |
| line_pix_i | input | PW | Requested transfer periods per line |
| gate_w_i | input | CW | Transfer gate width in cycles (G) |
| gate_su_i | input | CW | Gate-to-clocking setup in cycles (U) |
| vt_gap_i | input | CW | Memory transfer setup and hold around the second gate (M) |
| rst_w_i | input | HW | Pixel reset pulse width in cycles |
| smp_dly_i | input | HW | Sampling delay after the reset pulse |
| shclk1_o | output | 1 | Shift clock, phase 1 |
| shclk2_o | output | 1 | Shift clock, phase 2 |
| pixrst_o | output | 1 | Per-pixel reset pulse |
| xgate_a_o | output | 1 | Transfer gate, first row |
| xgate_b_o | output | 1 | Transfer gate, second row |
| mem_xfer_o | output | 1 | Delay-memory transfer clock |
| line_start_o | output | 1 | One-cycle line-start strobe |
| pix_valid_o | output | 1 | One-cycle sample strobe per pixel |

## Verification
The hardest case to reach from the ports is a setting that changes while a line is running. Such a change must not reach the outputs until the next gate window, so it is only visible if the inputs move at arbitrary points inside a line. The stimulus does exactly that. It switches the mode and every width part-way through lines, and in one phase it changes them every few cycles. The behavioural model captures the settings only at the line boundaries it computes itself. The clamps are also driven on purpose: zero widths, H = 1, a reset width larger than H, a sampling delay running past the period end, and a line length below the minimum.

// File: rtl/lccd_tg_pkg.sv
package lccd_tg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GATE  = 2'd1,
    SEQ_SETUP = 2'd2,
    SEQ_XFER  = 2'd3
  } seq_state_e;

  // zero-valued interval settings are read as one cycle
  function automatic int floor_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // length of the gate window: the memory transfer pulse wraps the
  // second-row gate with a margin on each side in delay mode
  function automatic int gate_span(input logic dly, input int g, input int m);
    return dly ? (g + 2 * m) : g;
  endfunction

  // sampling offset inside a pixel period, kept inside the period
  function automatic int sample_offset(input int w, input int d, input int h);
    return min_i(w + d, 2 * h - 1);
  endfunction

endpackage

// File: rtl/lccd_cfg_latch.sv
module lccd_cfg_latch
  import lccd_tg_pkg::*;
#(
  parameter int CW      = 16,
  parameter int HW      = 8,
  parameter int PW      = 12,
  parameter int MIN_PIX = 1047,
  localparam int SPW    = CW + 2,
  localparam int PHW    = HW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           delay_mode_i,
  input  logic [HW-1:0]  half_per_i,
  input  logic [PW-1:0]  line_pix_i,
  input  logic [CW-1:0]  gate_w_i,
  input  logic [CW-1:0]  gate_su_i,
  input  logic [CW-1:0]  vt_gap_i,
  input  logic [HW-1:0]  rst_w_i,
  input  logic [HW-1:0]  smp_dly_i,
  output logic           mode_q,
  output logic [SPW-1:0] span_last_q,
  output logic [SPW-1:0] su_last_q,
  output logic [SPW-1:0] gb_on_q,
  output logic [SPW-1:0] gb_off_q,
  output logic [PW-1:0]  n_last_q,
  output logic [PHW-1:0] half_q,
  output logic [PHW-1:0] per_last_q,
  output logic [PHW-1:0] rw_q,
  output logic [PHW-1:0] smp_q
);

  int g_e, m_e, u_e, h_e, n_e, w_e, o_e, on_e, span_e;

  always_comb begin
    g_e    = floor_one(int'(gate_w_i));
    m_e    = floor_one(int'(vt_gap_i));
    u_e    = floor_one(int'(gate_su_i));
    h_e    = floor_one(int'(half_per_i));
    n_e    = max_i(int'(line_pix_i), MIN_PIX);
    w_e    = min_i(floor_one(int'(rst_w_i)), h_e);
    o_e    = sample_offset(w_e, int'(smp_dly_i), h_e);
    span_e = gate_span(delay_mode_i, g_e, m_e);
    on_e   = delay_mode_i ? m_e : 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      span_last_q <= '0;
      su_last_q   <= '0;
      gb_on_q     <= '0;
      gb_off_q    <= SPW'(1);
      n_last_q    <= PW'(MIN_PIX - 1);
      half_q      <= PHW'(1);
      per_last_q  <= PHW'(1);
      rw_q        <= PHW'(1);
      smp_q       <= PHW'(1);
    end else if (load_i) begin
      mode_q      <= delay_mode_i;
      span_last_q <= SPW'(span_e - 1);
      su_last_q   <= SPW'(u_e - 1);
      gb_on_q     <= SPW'(on_e);
      gb_off_q    <= SPW'(on_e + g_e);
      n_last_q    <= PW'(n_e - 1);
      half_q      <= PHW'(h_e);
      per_last_q  <= PHW'(2 * h_e - 1);
      rw_q        <= PHW'(w_e);
      smp_q       <= PHW'(o_e);
    end
  end

endmodule

// File: rtl/lccd_pix_clk.sv
module lccd_pix_clk #(
  parameter int PHW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [PHW-1:0] half_i,
  input  logic [PHW-1:0] per_last_i,
  input  logic [PHW-1:0] rw_i,
  input  logic [PHW-1:0] smp_i,
  output logic           ph1_o,
  output logic           ph2_o,
  output logic           prst_o,
  output logic           pval_o,
  output logic           pix_end_o
);

  logic [PHW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pos_q <= '0;
    else if (!run_i)              pos_q <= '0;
    else if (pos_q == per_last_i) pos_q <= '0;
    else                          pos_q <= pos_q + PHW'(1);
  end

  // phase 1 is held high whenever transfer clocking is stopped
  assign ph1_o     = !run_i || (pos_q >= half_i);
  assign ph2_o     = !ph1_o;
  assign prst_o    = run_i && (pos_q < rw_i);
  assign pval_o    = run_i && (pos_q == smp_i);
  assign pix_end_o = run_i && (pos_q == per_last_i);

endmodule

// File: rtl/lccd_line_seq.sv
module lccd_line_seq
  import lccd_tg_pkg::*;
#(
  parameter int SPW = 18,
  parameter int PW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPW-1:0] span_last_i,
  input  logic [SPW-1:0] su_last_i,
  input  logic [PW-1:0]  n_last_i,
  input  logic           pix_end_i,
  output logic           load_o,
  output logic           in_gate_o,
  output logic           in_xfer_o,
  output logic           line_start_o,
  output logic [SPW-1:0] gate_cnt_o
);

  seq_state_e     st_q;
  logic [SPW-1:0] cnt_q;
  logic [PW-1:0]  pix_q;
  logic           last_pix;

  assign last_pix = pix_end_i && (pix_q == n_last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      pix_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          st_q  <= SEQ_GATE;
          cnt_q <= '0;
        end
        SEQ_GATE: begin
          if (cnt_q == span_last_i) begin
            st_q  <= SEQ_SETUP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + SPW'(1);
          end
        end
        SEQ_SETUP: begin
          if (cnt_q == su_last_i) begin
            st_q  <= SEQ_XFER;
            cnt_q <= '0;
            pix_q <= '0;
          end else begin
            cnt_q <= cnt_q + SPW'(1);
          end
        end
        SEQ_XFER: begin
          if (last_pix) begin
            st_q  <= SEQ_GATE;
            cnt_q <= '0;
          end else if (pix_end_i) begin
            pix_q <= pix_q + PW'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign load_o       = (st_q == SEQ_IDLE) || ((st_q == SEQ_XFER) && last_pix);
  assign in_gate_o    = (st_q == SEQ_GATE);
  assign in_xfer_o    = (st_q == SEQ_XFER);
  assign line_start_o = in_gate_o && (cnt_q == '0);
  assign gate_cnt_o   = cnt_q;

endmodule

// File: rtl/lccd_timing_gen.sv
module lccd_timing_gen #(
  parameter int CW      = 16,
  parameter int HW      = 8,
  parameter int PW      = 12,
  parameter int MIN_PIX = 1047
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          delay_mode_i,
  input  logic [HW-1:0] half_per_i,
  input  logic [PW-1:0] line_pix_i,
  input  logic [CW-1:0] gate_w_i,
  input  logic [CW-1:0] gate_su_i,
  input  logic [CW-1:0] vt_gap_i,
  input  logic [HW-1:0] rst_w_i,
  input  logic [HW-1:0] smp_dly_i,
  output logic          shclk1_o,
  output logic          shclk2_o,
  output logic          pixrst_o,
  output logic          xgate_a_o,
  output logic          xgate_b_o,
  output logic          mem_xfer_o,
  output logic          line_start_o,
  output logic          pix_valid_o
);

  localparam int SPW = CW + 2;
  localparam int PHW = HW + 1;

  // named internal events, also used by the bound checker
  logic           line_load;
  logic           in_gate;
  logic           in_xfer;
  logic           pix_end;
  logic [SPW-1:0] gate_cnt;
  logic           mode_q;
  logic [SPW-1:0] span_last_q, su_last_q, gb_on_q, gb_off_q;
  logic [PW-1:0]  n_last_q;
  logic [PHW-1:0] half_q, per_last_q, rw_q, smp_q;

  lccd_cfg_latch #(
    .CW(CW), .HW(HW), .PW(PW), .MIN_PIX(MIN_PIX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(line_load),
    .delay_mode_i(delay_mode_i), .half_per_i(half_per_i),
    .line_pix_i(line_pix_i), .gate_w_i(gate_w_i), .gate_su_i(gate_su_i),
    .vt_gap_i(vt_gap_i), .rst_w_i(rst_w_i), .smp_dly_i(smp_dly_i),
    .mode_q(mode_q), .span_last_q(span_last_q), .su_last_q(su_last_q),
    .gb_on_q(gb_on_q), .gb_off_q(gb_off_q), .n_last_q(n_last_q),
    .half_q(half_q), .per_last_q(per_last_q), .rw_q(rw_q), .smp_q(smp_q)
  );

  lccd_line_seq #(
    .SPW(SPW), .PW(PW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .span_last_i(span_last_q),
    .su_last_i(su_last_q), .n_last_i(n_last_q), .pix_end_i(pix_end),
    .load_o(line_load), .in_gate_o(in_gate), .in_xfer_o(in_xfer),
    .line_start_o(line_start_o), .gate_cnt_o(gate_cnt)
  );

  lccd_pix_clk #(
    .PHW(PHW)
  ) u_pix (
    .clk(clk), .rst_n(rst_n), .run_i(in_xfer), .half_i(half_q),
    .per_last_i(per_last_q), .rw_i(rw_q), .smp_i(smp_q),
    .ph1_o(shclk1_o), .ph2_o(shclk2_o), .prst_o(pixrst_o),
    .pval_o(pix_valid_o), .pix_end_o(pix_end)
  );

  // first-row gate and memory transfer share one timing; the second-row
  // gate is a window inside the gate span (the whole span in direct mode)
  assign xgate_a_o  = in_gate;
  assign mem_xfer_o = in_gate;
  assign xgate_b_o  = in_gate && (gate_cnt >= gb_on_q) && (gate_cnt < gb_off_q);

endmodule

// File: rtl/lccd_timing_chk.sv
module lccd_timing_chk #(
  parameter int MIN_PIX = 1047,
  parameter int PW      = 12,
  parameter int PHW     = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           shclk1_o,
  input logic           shclk2_o,
  input logic           pixrst_o,
  input logic           xgate_a_o,
  input logic           xgate_b_o,
  input logic           line_start_o,
  input logic           pix_valid_o,
  input logic           mode_q,
  input logic [PW-1:0]  n_last_q,
  input logic [PHW-1:0] per_last_q
);

  logic        ph2_d;
  logic        seen_line;
  int unsigned period_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2_d      <= 1'b0;
      seen_line  <= 1'b0;
      period_cnt <= 0;
    end else begin
      ph2_d <= shclk2_o;
      if (line_start_o) begin
        seen_line  <= 1'b1;
        period_cnt <= 0;
      end else if (shclk2_o && !ph2_d) begin
        period_cnt <= period_cnt + 1;
      end
    end
  end

  p_gate_static_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xgate_a_o |-> (shclk1_o && !pixrst_o && !pix_valid_o));

  p_direct_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (xgate_b_o == xgate_a_o));

  p_delay_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && xgate_b_o) |-> xgate_a_o);

  p_delay_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $rose(xgate_a_o)) |-> !xgate_b_o);

  p_reset_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pixrst_o |-> shclk2_o);

  p_sample_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> !pixrst_o);

  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> !line_start_o);

  p_line_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_o && seen_line) |-> (period_cnt >= MIN_PIX));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_o |-> ($stable(mode_q) && $stable(n_last_q) && $stable(per_last_q)));

endmodule

bind lccd_timing_gen lccd_timing_chk #(
  .MIN_PIX(MIN_PIX), .PW(PW), .PHW(HW + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shclk1_o(shclk1_o), .shclk2_o(shclk2_o),
  .pixrst_o(pixrst_o), .xgate_a_o(xgate_a_o), .xgate_b_o(xgate_b_o),
  .line_start_o(line_start_o), .pix_valid_o(pix_valid_o),
  .mode_q(mode_q), .n_last_q(n_last_q), .per_last_q(per_last_q)
);

// File: tb/tb_lccd_timing_gen.sv
module tb_lccd_timing_gen;

  localparam int MINP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dmode;
  logic [7:0]  half, rst_w, smp_dly;
  logic [11:0] line_pix;
  logic [15:0] gate_w, gate_su, vt_gap;
  logic shclk1, shclk2, pixrst, xga, xgb, mxf, ls, pv;

  always #10 clk = ~clk;  // 50 MHz

  lccd_timing_gen #(.CW(16), .HW(8), .PW(12), .MIN_PIX(MINP)) dut (
    .clk(clk), .rst_n(rst_n), .delay_mode_i(dmode), .half_per_i(half),
    .line_pix_i(line_pix), .gate_w_i(gate_w), .gate_su_i(gate_su),
    .vt_gap_i(vt_gap), .rst_w_i(rst_w), .smp_dly_i(smp_dly),
    .shclk1_o(shclk1), .shclk2_o(shclk2), .pixrst_o(pixrst),
    .xgate_a_o(xga), .xgate_b_o(xgb), .mem_xfer_o(mxf),
    .line_start_o(ls), .pix_valid_o(pv)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string scn = "base";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d t=%0t",
               tag, scn, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_t, m_L, m_A, m_G, m_M, m_U, m_H, m_N, m_W, m_O, m_prevN;
  bit  m_mode, m_on = 0;

  always @(posedge clk) begin
    if (!rst_n) m_on = 0;
    else if (!m_on || m_t == m_L - 1) begin
      m_prevN = m_N;
      m_mode = dmode;
      m_G = (gate_w == 0) ? 1 : int'(gate_w);
      m_M = (vt_gap == 0) ? 1 : int'(vt_gap);
      m_U = (gate_su == 0) ? 1 : int'(gate_su);
      m_H = (half == 0) ? 1 : int'(half);
      m_N = (int'(line_pix) < MINP) ? MINP : int'(line_pix);
      m_W = (rst_w == 0) ? 1 : int'(rst_w);
      if (m_W > m_H) m_W = m_H;
      m_O = m_W + int'(smp_dly);
      if (m_O > 2 * m_H - 1) m_O = 2 * m_H - 1;
      m_A = m_mode ? m_G + 2 * m_M : m_G;
      m_L = m_A + m_U + 2 * m_H * m_N;
      m_t = 0;
      m_on = 1;
    end else m_t++;
  end

  // ---------------- per-cycle comparison ----------------
  bit e1, eA, eB, eR, eV, eS, prev2 = 0, have_prev = 0;
  int p, obs_rise = 0;
  string tphi, tgate;

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || !m_on) begin
        chk(shclk1 && !shclk2 && !pixrst && !xga && !xgb && !mxf && !ls && !pv,
            "R1", "idle/reset outputs {ph1,ph2,rst,ga,gb,mx,ls,pv}",
            {shclk1, shclk2, pixrst, xga, xgb, mxf, ls, pv}, 8'b1000_0000);
      end else begin
        eA = (m_t < m_A);
        eB = eA && (!m_mode || (m_t >= m_M && m_t < m_M + m_G));
        e1 = 1; eR = 0; eV = 0;
        if (m_t >= m_A + m_U) begin
          p  = (m_t - m_A - m_U) % (2 * m_H);
          e1 = (p >= m_H);
          eR = (p < m_W);
          eV = (p == m_O);
        end
        eS = (m_t == 0);
        tphi  = (m_t < m_A + m_U) ? "R6" : "R2";
        tgate = m_mode ? "R5" : "R4";
        chk(shclk1 == e1, tphi, "shclk1", shclk1, e1);
        chk(shclk2 == !e1, tphi, "shclk2", shclk2, !e1);
        chk(xga == eA, tgate, "xgate_a", xga, eA);
        chk(xgb == eB, tgate, "xgate_b", xgb, eB);
        chk(mxf == xga && mxf == eA, "R3", "mem_xfer", mxf, eA);
        chk(pixrst == eR, (m_t < m_A + m_U) ? "R6" : "R8", "pixrst", pixrst, eR);
        chk(pv == eV, "R9", "pix_valid", pv, eV);
        chk(ls == eS, "R10", "line_start", ls, eS);
        // R7: transfer periods counted at the ports between line starts
        if (ls) begin
          if (have_prev) chk(obs_rise == m_prevN, "R7", "periods per line", obs_rise, m_prevN);
          have_prev = 1;
          obs_rise = 0;
        end else if (shclk2 && !prev2) obs_rise++;
      end
      prev2 = shclk2;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_lines(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (ls) k++;
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    dmode = 0; half = 2; line_pix = 5; gate_w = 4; gate_su = 3; vt_gap = 2;
    rst_w = 1; smp_dly = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R4 direct mode, line shorter than minimum (R7 clamp)
    scn = "direct";
    wait_lines(3);
    // R11: mode and widths switched part-way through a line
    scn = "R11";
    repeat (9) @(negedge clk);
    dmode = 1; half = 3; line_pix = 30; gate_w = 5; vt_gap = 3; gate_su = 2;
    rst_w = 0; smp_dly = 10;
    wait_lines(3);
    // corners: H=1, zero widths, reset width over H (R5 R8 R9)
    scn = "zero";
    repeat (4) @(negedge clk);
    half = 0; gate_w = 0; gate_su = 0; vt_gap = 0; rst_w = 4; smp_dly = 0;
    line_pix = 24;
    wait_lines(3);
    // reset width clamps to H, sample offset clamps to period end
    scn = "clamp";
    dmode = 0; half = 4; rst_w = 9; smp_dly = 200; line_pix = 25; gate_w = 7;
    gate_su = 5;
    wait_lines(3);
    // R11: settings churn every few cycles across whole lines
    scn = "R11";
    for (int i = 0; i < 120; i++) begin
      repeat (7) @(negedge clk);
      dmode = ~dmode;
      half = 8'((i % 5) + 1);
      gate_w = 16'((i % 4) + 1);
      vt_gap = 16'(i % 3);
      gate_su = 16'((i % 6));
      rst_w = 8'(i % 4);
      smp_dly = 8'(i % 9);
      line_pix = 12'(20 + (i % 8));
    end
    wait_lines(2);
    finish_up();
  end

endmodule